// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Zero Read/Write Turnaround

This block is a synthesizable behavioural model of a small synchronous SRAM with flow-through read data. The rising clock edge registers every control, address and write-data input. Reads and writes can follow each other in any order on consecutive cycles, with no idle cycle between them.

Read data comes straight from the array during the cycle after its address is registered. Write data trails its address by one cycle. The write data and its byte-lane enables are held in a one-entry write buffer and committed to the array one active edge later. A read of a word that is still in that buffer is served from the buffer.

An access is started with a load command. It can then be extended into a four-beat burst with advance commands, in either linear or interleaved order. Three chip selects gate new accesses. An active-low clock enable freezes the whole block. An asynchronous output enable controls the data bus, which is split into separate in, out and drive-enable ports.

Top module: `ft_sram`

## Requirements
- R1: At a rising edge with `cke_n` low, `ld_n` low and all three selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0), an access to `addr` starts. It is a write when `we_n` is 0 and a read when `we_n` is 1.
- R2: For a read beat registered at edge N, `dq_oe` is 1 and `dq_out` holds the word's current contents from after edge N until edge N+1, provided `oe_n` is low.
- R3: For a write beat registered at edge N, the word is taken from `dq_in` at the next active edge. Only the byte lanes selected at edge N are updated. `bw_n[i]`=0 enables lane i, which is data bits [9i+8:9i]. The other lanes keep their contents.
- R4: A read registered on the edge right after a write to the same word returns the new data, with the lanes merged. Writes and reads may alternate on every cycle.
- R5: Each edge with `ld_n` high continues the current burst in the same direction, for at most four beats in total. Beat k (k = 0..3) keeps the upper address bits. Its two low bits are base XOR k when `burst_ilv`=1, and base+k modulo 4 when `burst_ilv`=0. An advance past the fourth beat, or with no burst open, starts nothing.
- R6: An edge with `ld_n` low and any select inactive starts no access and closes any open burst. Write data owed to the previous beat is still captured at that edge.
- R7: An edge with `cke_n` high ignores every synchronous input and changes no state: no beat, no write capture, no array update. The outputs stay as they were.
- R8: `dq_oe` is 0 during the cycle after a write beat, a deselect or an advance that starts nothing.
- R9: `oe_n` high forces `dq_oe` to 0 at once, with no clock edge needed. `dq_out` is all zeros whenever `dq_oe` is 0.
- R10: Reset clears the control pipeline, so `dq_oe` is 0 with no access open. Array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| we_n | input | 1 | Direction on load: 0 write, 1 read |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A read beat is due in the window between its own edge and the next edge. The write data for a beat is due on the bus one active edge after that beat, and any stalled edges push it later. The driver task updates a reference array at the edge where the write data is taken. It pushes the expected bus state for the window that follows each edge it drives. The monitor pops and compares that state 3 ns after the edge, well before the next edge. The asynchronous output-enable check is made half a nanosecond after `oe_n` changes in the middle of a cycle, with no clock edge in between.

// File: rtl/ft_sram_pkg.sv
`timescale 1ns/1ps
package ft_sram_pkg;
   localparam int CNT_W = 2;
   localparam int BEATS = 1 << CNT_W;

   // Low address bits of a burst beat from the loaded base and the beat index.
   function automatic logic [CNT_W-1:0] beat_lo(input logic [CNT_W-1:0] base,
                                                input logic [CNT_W-1:0] idx,
                                                input logic             ilv);
      return ilv ? (base ^ idx) : (base + idx);
   endfunction
endpackage

// File: rtl/ft_sram_seq.sv
`timescale 1ns/1ps
// Command decode, burst counter and access register.
module ft_sram_seq #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              sel,
   input  logic              ld_n,
   input  logic              we_n,
   input  logic              ilv,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              acc_vld,
   output logic              acc_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  acc_bw
);
   import ft_sram_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

   logic              brst_act;
   logic              brst_wr;
   logic [ADDR_W-1:0] base;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_nx;

   assign cnt_nx = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brst_act <= 1'b0;
         brst_wr  <= 1'b0;
         base     <= '0;
         cnt      <= '0;
         acc_vld  <= 1'b0;
         acc_wr   <= 1'b0;
         acc_addr <= '0;
         acc_bw   <= '0;
      end else if (!cke_n) begin
         if (!ld_n) begin
            if (sel) begin
               brst_act <= 1'b1;
               brst_wr  <= ~we_n;
               base     <= addr;
               cnt      <= '0;
               acc_vld  <= 1'b1;
               acc_wr   <= ~we_n;
               acc_addr <= addr;
               acc_bw   <= ~bw_n;
            end else begin
               brst_act <= 1'b0;
               acc_vld  <= 1'b0;
            end
         end else if (brst_act) begin
            cnt      <= cnt_nx;
            brst_act <= (cnt_nx != LAST);
            acc_vld  <= 1'b1;
            acc_wr   <= brst_wr;
            acc_addr <= {base[ADDR_W-1:CNT_W], beat_lo(base[CNT_W-1:0], cnt_nx, ilv)};
            acc_bw   <= ~bw_n;
         end else begin
            acc_vld  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ft_sram_store.sv
`timescale 1ns/1ps
// Array, one-entry late-write buffer and lane-wise read forwarding.
module ft_sram_store #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    acc_vld,
   input  logic                    acc_wr,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [LANES-1:0]        acc_bw,
   input  logic [LANES*LANE_W-1:0] wr_dat,
   output logic [LANES*LANE_W-1:0] rd_dat,
   output logic                    wr_pend
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_bw;
   logic [DATA_W-1:0] pend_dat;
   logic [DATA_W-1:0] arr_word;
   logic              hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_pend <= 1'b0;
      else if (!cke_n) wr_pend <= acc_vld & acc_wr;
   end

   always_ff @(posedge clk) begin
      if (!cke_n && acc_vld && acc_wr) begin
         pend_addr <= acc_addr;
         pend_bw   <= acc_bw;
         pend_dat  <= wr_dat;
      end
   end

   always_ff @(posedge clk) begin
      if (!cke_n && wr_pend) begin
         for (int l = 0; l < LANES; l++) begin
            if (pend_bw[l]) mem[pend_addr][l*LANE_W +: LANE_W] <= pend_dat[l*LANE_W +: LANE_W];
         end
      end
   end

   assign arr_word = mem[acc_addr];
   assign hit      = wr_pend && (pend_addr == acc_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rd_dat[g*LANE_W +: LANE_W] = (hit && pend_bw[g]) ? pend_dat[g*LANE_W +: LANE_W]
                                                              : arr_word[g*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/ft_sram.sv
`timescale 1ns/1ps
module ft_sram #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    ld_n,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    burst_ilv,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   import ft_sram_pkg::*;

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("ft_sram: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ft_sram: LANES and LANE_W must be at least 1");
   end

   logic              sel;
   logic              acc_vld;
   logic              acc_wr;
   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  acc_bw;
   logic [DATA_W-1:0] rd_dat;
   logic              wr_pend;

   assign sel = ~cs1_n & cs2 & ~cs3_n;

   ft_sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel(sel), .ld_n(ld_n),
      .we_n(we_n), .ilv(burst_ilv), .bw_n(bw_n), .addr(addr),
      .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_bw(acc_bw)
   );

   ft_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_bw(acc_bw), .wr_dat(dq_in), .rd_dat(rd_dat),
      .wr_pend(wr_pend)
   );

   assign dq_oe  = acc_vld & ~acc_wr & ~oe_n;
   assign dq_out = dq_oe ? rd_dat : '0;
endmodule

// File: rtl/ft_sram_chk.sv
`timescale 1ns/1ps
module ft_sram_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              ld_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              dq_oe,
   input logic              acc_vld,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              wr_pend
);
   logic chosen;
   assign chosen = !cs1_n && cs2 && !cs3_n;

   // R1
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && chosen) |=> (acc_vld && acc_addr == $past(addr) && acc_wr == !$past(we_n)));

   // R6
   desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && !chosen) |=> !acc_vld);

   // R8
   desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && !chosen) |=> !dq_oe);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(acc_vld) && $stable(acc_addr) && $stable(acc_wr) && $stable(wr_pend)));

   // R3
   late_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && acc_vld && acc_wr) |=> wr_pend);

   // R5
   burst_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && ld_n && acc_vld) |=>
         (!acc_vld || (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]) && acc_wr == $past(acc_wr))));
endmodule

bind ft_sram ft_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
   .ld_n(ld_n), .we_n(we_n), .addr(addr), .dq_oe(dq_oe), .acc_vld(acc_vld),
   .acc_wr(acc_wr), .acc_addr(acc_addr), .wr_pend(wr_pend)
);

// File: tb/ft_sram_test.sv
`timescale 1ns/100ps
module ft_sram_test;
   localparam int AW = 8;
   localparam int NL = 2;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
   logic          ld_n = 1'b1, we_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
   logic [NL-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .burst_ilv(burst_ilv),
      .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [DW-1:0] ref_mem [1<<AW];
   logic          m_act = 0, m_bdir = 0, m_vld = 0, m_wr = 0, m_ilv = 0;
   logic [AW-1:0] m_base = '0, m_addr = '0;
   logic [1:0]    m_cnt = '0;
   logic [NL-1:0] m_bw = '0;

   logic          q_oe [$];
   logic [DW-1:0] q_d  [$];
   string         q_tag[$];

   task automatic check(input bit ok, input string tag,
                        input logic a_oe, input logic [DW-1:0] a_d,
                        input logic e_oe, input logic [DW-1:0] e_d);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h", tag, a_oe, a_d, e_oe, e_d);
      end
   endtask

   // Monitor: compare each due window 3 ns after its edge.
   always @(posedge clk) begin
      #3;
      if (q_oe.size() > 0) begin
         logic          e_oe;
         logic [DW-1:0] e_d;
         string         t;
         e_oe = q_oe.pop_front();
         e_d  = q_d.pop_front();
         t    = q_tag.pop_front();
         check(dq_oe === e_oe && dq_out === e_d, t, dq_oe, dq_out, e_oe, e_d);
      end
   end

   // Driver: drive one edge's inputs, update the model, push the expected window.
   task automatic step(input logic ck, input logic ld, input logic c1n, input logic c2,
                       input logic c3n, input logic we, input logic [NL-1:0] bw,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe,
                       input string tag);
      logic          e_oe;
      logic [DW-1:0] e_d;
      @(negedge clk);
      cke_n = ck; ld_n = ld; cs1_n = c1n; cs2 = c2; cs3_n = c3n; we_n = we;
      bw_n = bw; addr = a; dq_in = d; oe_n = oe; burst_ilv = m_ilv;
      if (!ck) begin
         if (m_vld && m_wr)
            for (int l = 0; l < NL; l++)
               if (m_bw[l]) ref_mem[m_addr][l*LW +: LW] = d[l*LW +: LW];
         if (!ld) begin
            if (!c1n && c2 && !c3n) begin
               m_act = 1; m_bdir = !we; m_base = a; m_cnt = 0;
               m_vld = 1; m_wr = !we; m_addr = a; m_bw = ~bw;
            end else begin
               m_act = 0; m_vld = 0;
            end
         end else if (m_act && m_cnt != 2'd3) begin
            m_cnt = m_cnt + 2'd1;
            m_vld = 1; m_wr = m_bdir; m_bw = ~bw;
            m_addr = {m_base[AW-1:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
         end else begin
            m_act = 0; m_vld = 0;
         end
      end
      e_oe = m_vld && !m_wr && !oe;
      e_d  = e_oe ? ref_mem[m_addr] : '0;
      q_oe.push_back(e_oe);
      q_d.push_back(e_d);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw, input logic [DW-1:0] d, input string tag);
      step(0, 0, 0, 1, 0, 0, bw, a, d, 0, tag);
   endtask
   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe, input string tag);
      step(0, 0, 0, 1, 0, 1, '1, a, d, oe, tag);
   endtask
   task automatic adv(input logic [NL-1:0] bw, input logic [DW-1:0] d, input string tag);
      step(0, 1, 1, 0, 1, 1, bw, 8'hEE, d, 0, tag);
   endtask
   task automatic desel(input logic [DW-1:0] d, input logic c1n, input logic c2, input string tag);
      step(0, 0, c1n, c2, 1, 0, '0, 8'h33, d, 0, tag);
   endtask
   task automatic stall(input logic [DW-1:0] d, input string tag);
      step(1, 0, 0, 1, 0, 0, '0, 8'h20, d, 0, tag);
   endtask

   task automatic drain();
      repeat (2) @(posedge clk);
      #4;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      m_act = 0; m_vld = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      #1;
      check(dq_oe === 1'b0 && dq_out === '0, "R10 reset state", dq_oe, dq_out, 1'b0, '0);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      do_reset();

      // single write, data one edge later on a deselect edge, then read
      wr(8'h10, 2'b00, '0, "R1 write load");
      desel(18'h2A5A5, 1, 1, "R6 data after deselect");
      rd(8'h10, '0, 0, "R2 read flow-through");
      // write immediately followed by read of the same word
      wr(8'h20, 2'b00, '0, "R8 no drive after write beat");
      rd(8'h20, 18'h1F00F, 0, "R4 read right after write");
      wr(8'h20, 2'b10, '0, "R3 lane0 write");
      rd(8'h20, 18'h3F0C3, 0, "R3 lane0 merged forward");
      rd(8'h20, '0, 0, "R3 lane0 from array");
      wr(8'h20, 2'b01, '0, "R3 lane1 write");
      desel(18'h15555, 0, 0, "R6 cs2 low deselect");
      rd(8'h20, '0, 0, "R3 lane1 merged");
      desel('0, 1, 1, "R8 deselect float");

      // linear write burst, fifth advance starts nothing
      m_ilv = 0;
      wr(8'h40, 2'b00, '0, "R5 burst write load");
      adv(2'b00, 18'h00111, "R5 burst write beat1");
      adv(2'b00, 18'h00222, "R5 burst write beat2");
      adv(2'b00, 18'h00333, "R5 burst write beat3");
      adv(2'b00, 18'h00444, "R5 fifth advance idle");
      rd(8'h42, '0, 0, "R5 linear read base");
      adv(2'b11, '0, "R5 linear beat1");
      adv(2'b11, '0, "R5 linear beat2");
      adv(2'b11, '0, "R5 linear beat3");
      adv(2'b11, '0, "R5 linear fifth idle");
      desel('0, 1, 1, "R8 idle");
      drain();
      m_ilv = 1;
      rd(8'h41, '0, 0, "R5 interleaved base");
      adv(2'b11, '0, "R5 interleaved beat1");
      adv(2'b11, '0, "R5 interleaved beat2");
      adv(2'b11, '0, "R5 interleaved beat3");
      rd(8'h43, '0, 0, "R5 interleaved base3");
      adv(2'b11, '0, "R5 interleaved b3 beat1");
      adv(2'b11, '0, "R5 interleaved b3 beat2");
      // deselect mid burst, then advance does nothing
      rd(8'h40, '0, 0, "R6 burst before stop");
      adv(2'b11, '0, "R6 burst beat1");
      desel('0, 1, 1, "R6 burst stopped");
      adv(2'b11, '0, "R6 advance after stop");

      // stalls inside a write burst and after a read
      m_ilv = 0;
      wr(8'h80, 2'b00, '0, "R7 write before stall");
      stall(18'h3FFFF, "R7 stall ignores data");
      adv(2'b00, 18'h0ABCD, "R7 data after stall");
      stall(18'h3FFFF, "R7 stall again");
      desel(18'h12345, 1, 1, "R7 second data");
      rd(8'h80, '0, 0, "R7 read stalled write");
      stall('0, "R7 read held in stall");
      stall('0, "R7 read held second stall");
      rd(8'h81, '0, 0, "R7 read burst word");

      // output enable
      rd(8'h10, '0, 1, "R9 oe high no drive");
      rd(8'h10, '0, 0, "R9 oe low drives");
      @(posedge clk);
      #4 oe_n = 1;
      #0.5 check(dq_oe === 1'b0 && dq_out === '0, "R9 async oe release", dq_oe, dq_out, 1'b0, '0);
      oe_n = 0;

      // alternating write/read every cycle
      for (int i = 0; i < 8; i++) begin
         logic [DW-1:0] dv;
         dv = DW'(i * 18'h04D3B + 18'h01234);
         wr(AW'(8'hA0 + i), 2'b00, '0, "R4 alternating write");
         rd(AW'(8'hA0 + i), dv, 0, "R4 alternating read");
      end
      for (int i = 0; i < 8; i++) rd(AW'(8'hA0 + i), '0, 0, "R4 readback");
      desel('0, 1, 1, "R8 idle before reset");
      drain();

      do_reset();
      rd(8'h10, '0, 0, "R10 array kept over reset");
      rd(8'h80, '0, 0, "R10 array kept over reset b");
      desel('0, 1, 1, "R8 final idle");
      drain();
      report();
      $finish;
   end
endmodule